// File: doc/BRIEF.md
# Per-Core Interrupt Intake and Selection

This block sits in front of one processor core and takes in interrupt messages. Each message carries a vector, a delivery mode, a trigger flag and a destination field. The block first decides whether the message is meant for this core. Ordinary requests (fixed and lowest-priority) are then kept in a bit array indexed by vector, with a second array that remembers the trigger style of each vector. The four special kinds (system-management, non-maskable, init and external) each wait in a dedicated one-deep slot that also holds their vector.

Every cycle the block shows the interrupt the core should take next, with its kind, its vector and, for ordinary requests, its trigger style. A one-cycle acknowledge retires whatever is shown at that moment. Special slots always win over queued ordinary vectors, in a fixed order among themselves.

Top module: `irq_accept_arb`

## Requirements
- R1: A message with mode 000 (fixed) or 001 (lowest-priority) sets the request bit of its vector. The trigger bit of that vector takes msg_level (1 = level, 0 = edge) only if the request bit was clear beforehand. While that vector is shown, irq_level reports its trigger bit.
- R2: When no special slot is pending, irq_kind is 5 (ordinary) and irq_vector is the highest vector whose request bit is set. This includes vectors 0 and 255.
- R3: Modes 010 (system-management), 100 (non-maskable), 101 (init) and 111 (external) never touch the request array. Each one fills its own slot and captures the vector of the message.
- R4: A special message whose slot is already pending is ignored, and the vector captured first is kept.
- R5: unmask_pending is high exactly while a system-management, non-maskable or init slot is pending. An external slot does not raise it.
- R6: Messages with the reserved modes 011 and 110 change no state.
- R7: Selection order, with its irq_kind code: system-management (1), non-maskable (2), init (3), external (4), then the highest ordinary vector (5). Code 0 means nothing is pending.
- R8: A message is accepted when msg_dest_logical=0 and msg_dest equals local_id, or when msg_dest_logical=1 and bit local_id of msg_dest is set. Any other message is dropped.
- R9: ack retires the interrupt shown in that cycle. For a special interrupt it clears that slot. For an ordinary interrupt it clears that vector's request bit, and the next highest vector, or none, is shown. ack while nothing is pending has no effect.
- R10: irq_pending is high whenever any special slot or any request bit is set.
- R11: A synchronous active-high reset clears all slots, both arrays and the highest-vector register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| local_id | input | 3 | Identity of this core within the destination field |
| msg_valid | input | 1 | A message is present this cycle |
| msg_vector | input | 8 | Vector of the message |
| msg_mode | input | 3 | Delivery mode code |
| msg_level | input | 1 | Trigger flag, 1 = level |
| msg_dest_logical | input | 1 | Destination interpretation, 1 = bit mask |
| msg_dest | input | 8 | Destination field |
| ack | input | 1 | Retire the interrupt currently shown |
| irq_pending | output | 1 | Something is waiting |
| irq_kind | output | 3 | Kind of the interrupt shown |
| irq_vector | output | 8 | Vector of the interrupt shown |
| irq_level | output | 1 | Trigger bit of the shown ordinary vector |
| unmask_pending | output | 1 | A non-maskable class slot is pending |

## Verification
The assertions assume that ack is raised only to retire the interrupt currently shown. They also assume that msg_mode and msg_vector carry defined values whenever msg_valid is high. Stimulus is applied on the falling edge, with one message or one acknowledge per cycle, and each acknowledge is preceded by a check of the shown interrupt. Checks on stability after a dropped or reserved message are made only in cycles without an acknowledge.

// File: rtl/lic_pkg.sv
package lic_pkg;
   typedef enum logic [2:0] {
      DM_FIXED  = 3'b000,
      DM_LOWEST = 3'b001,
      DM_SMI    = 3'b010,
      DM_RSV3   = 3'b011,
      DM_NMI    = 3'b100,
      DM_INIT   = 3'b101,
      DM_RSV6   = 3'b110,
      DM_EXT    = 3'b111
   } dmode_t;

   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_SMI   = 3'd1,
      K_NMI   = 3'd2,
      K_INIT  = 3'd3,
      K_EXT   = 3'd4,
      K_FIXED = 3'd5
   } kind_t;

   localparam int NUM_SLOTS = 4;   // slot order is the selection priority
endpackage

// File: rtl/lic_dest_match.sv
module lic_dest_match #(
   parameter int DEST_W    = 8,
   parameter bit LOGICAL_EN = 1'b1,
   localparam int ID_W     = $clog2(DEST_W)
) (
   input  logic [ID_W-1:0]   local_id,
   input  logic              dest_logical,
   input  logic [DEST_W-1:0] dest,
   output logic              hit
);
   logic phys_hit;
   assign phys_hit = (dest == DEST_W'(local_id));

   generate
      if (DEST_W < 2 || (1 << ID_W) != DEST_W) begin : g_bad
         $error("lic_dest_match: DEST_W must be a power of two >= 2");
      end
      if (LOGICAL_EN) begin : g_logical
         assign hit = dest_logical ? dest[local_id] : phys_hit;
      end else begin : g_phys_only
         assign hit = !dest_logical && phys_hit;
      end
   endgenerate
endmodule

// File: rtl/lic_special_slots.sv
module lic_special_slots
   import lic_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 req_valid,
   input  dmode_t               req_mode,
   input  logic [VEC_W-1:0]     req_vec,
   input  logic [NUM_SLOTS-1:0] clr,
   output logic [NUM_SLOTS-1:0] pend,
   output logic [VEC_W-1:0]     vec [NUM_SLOTS],
   output logic                 unmask
);
   localparam dmode_t SLOT_MODE [NUM_SLOTS] = '{DM_SMI, DM_NMI, DM_INIT, DM_EXT};

   logic [NUM_SLOTS-1:0] pend_nxt;

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic take;
         assign take = req_valid && (req_mode == SLOT_MODE[s]) && (!pend[s] || clr[s]);
         assign pend_nxt[s] = take || (pend[s] && !clr[s]);

         always_ff @(posedge clk) begin
            if (rst) begin
               pend[s] <= 1'b0;
               vec[s]  <= '0;
            end else begin
               pend[s] <= pend_nxt[s];
               if (take) vec[s] <= req_vec;
            end
         end

         AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (rst)
            pend[s] && !clr[s] |=> pend[s] && $stable(vec[s]))
            else $error("special slot vector changed while pending"); // R4
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) unmask <= 1'b0;
      else     unmask <= |pend_nxt[2:0];
   end

   AST_UNMASK_SUM: assert property (@(posedge clk) disable iff (rst)
      unmask == (|pend[2:0]))
      else $error("unmask summary disagrees with slots"); // R5
endmodule

// File: rtl/lic_vector_queue.sv
module lic_vector_queue #(
   parameter int VEC_W = 8,
   localparam int NUM_VEC = 1 << VEC_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             set_valid,
   input  logic [VEC_W-1:0] set_vec,
   input  logic             set_level,
   input  logic             clr_top,
   output logic             hi_valid,
   output logic [VEC_W-1:0] hi_vec,
   output logic             hi_level
);
   logic [NUM_VEC-1:0] req_q, trig_q, set_mask, clr_mask, req_nxt;
   logic [VEC_W-1:0]   top;
   logic               found;

   generate
      if (VEC_W < 1 || VEC_W > 10) begin : g_bad
         $error("lic_vector_queue: VEC_W out of range");
      end
   endgenerate

   assign set_mask = set_valid ? (NUM_VEC'(1) << set_vec) : '0;
   assign clr_mask = clr_top   ? (NUM_VEC'(1) << hi_vec)  : '0;
   assign req_nxt  = (req_q & ~clr_mask) | set_mask;

   always_comb begin
      top   = '0;
      found = 1'b0;
      for (int i = 0; i < NUM_VEC; i++) begin
         if (req_nxt[i]) begin
            top   = VEC_W'(i);
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         req_q    <= '0;
         trig_q   <= '0;
         hi_valid <= 1'b0;
         hi_vec   <= '0;
      end else begin
         req_q <= req_nxt;
         if (set_valid && (!req_q[set_vec] || clr_mask[set_vec]))
            trig_q[set_vec] <= set_level;
         if (clr_top) begin
            hi_valid <= found;
            hi_vec   <= top;
         end else if (set_valid && (!hi_valid || set_vec > hi_vec)) begin
            hi_valid <= 1'b1;
            hi_vec   <= set_vec;
         end
      end
   end

   assign hi_level = hi_valid && trig_q[hi_vec];

   AST_HI_IS_SET: assert property (@(posedge clk) disable iff (rst)
      hi_valid |-> req_q[hi_vec])
      else $error("highest vector register points at a clear bit"); // R2
   AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (rst)
      !hi_valid |-> req_q == '0)
      else $error("request bits set but none reported"); // R10
   AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
      set_valid |=> req_q[$past(set_vec)])
      else $error("queued vector not recorded"); // R1
endmodule

// File: rtl/irq_accept_arb.sv
module irq_accept_arb
   import lic_pkg::*;
#(
   parameter int VEC_W      = 8,
   parameter int DEST_W     = 8,
   parameter bit LOGICAL_EN = 1'b1,
   localparam int ID_W      = $clog2(DEST_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ID_W-1:0]   local_id,
   input  logic              msg_valid,
   input  logic [VEC_W-1:0]  msg_vector,
   input  logic [2:0]        msg_mode,
   input  logic              msg_level,
   input  logic              msg_dest_logical,
   input  logic [DEST_W-1:0] msg_dest,
   input  logic              ack,
   output logic              irq_pending,
   output logic [2:0]        irq_kind,
   output logic [VEC_W-1:0]  irq_vector,
   output logic              irq_level,
   output logic              unmask_pending
);
   dmode_t               mode;
   logic                 hit, accept, is_queued, is_special;
   logic [NUM_SLOTS-1:0] pend, grant, slot_clr;
   logic [VEC_W-1:0]     slot_vec [NUM_SLOTS];
   logic                 hi_valid, hi_level, fixed_grant;
   logic [VEC_W-1:0]     hi_vec;
   kind_t                kind;

   assign mode       = dmode_t'(msg_mode);
   assign is_queued  = (mode == DM_FIXED) || (mode == DM_LOWEST);
   assign is_special = (mode == DM_SMI) || (mode == DM_NMI) ||
                       (mode == DM_INIT) || (mode == DM_EXT);

   lic_dest_match #(.DEST_W(DEST_W), .LOGICAL_EN(LOGICAL_EN)) u_match (
      .local_id(local_id), .dest_logical(msg_dest_logical),
      .dest(msg_dest), .hit(hit));

   assign accept = msg_valid && hit;

   lic_special_slots #(.VEC_W(VEC_W)) u_slots (
      .clk(clk), .rst(rst),
      .req_valid(accept && is_special), .req_mode(mode), .req_vec(msg_vector),
      .clr(slot_clr), .pend(pend), .vec(slot_vec), .unmask(unmask_pending));

   lic_vector_queue #(.VEC_W(VEC_W)) u_queue (
      .clk(clk), .rst(rst),
      .set_valid(accept && is_queued), .set_vec(msg_vector), .set_level(msg_level),
      .clr_top(ack && fixed_grant),
      .hi_valid(hi_valid), .hi_vec(hi_vec), .hi_level(hi_level));

   // fixed priority: lowest slot index wins, queued vectors last
   always_comb begin
      grant = '0;
      for (int s = 0; s < NUM_SLOTS; s++)
         if (pend[s] && grant == '0) grant[s] = 1'b1;
   end
   assign fixed_grant = (grant == '0) && hi_valid;
   assign slot_clr    = ack ? grant : '0;

   always_comb begin
      kind       = K_NONE;
      irq_vector = '0;
      irq_level  = 1'b0;
      if      (grant[0]) begin kind = K_SMI;  irq_vector = slot_vec[0]; end
      else if (grant[1]) begin kind = K_NMI;  irq_vector = slot_vec[1]; end
      else if (grant[2]) begin kind = K_INIT; irq_vector = slot_vec[2]; end
      else if (grant[3]) begin kind = K_EXT;  irq_vector = slot_vec[3]; end
      else if (hi_valid) begin
         kind       = K_FIXED;
         irq_vector = hi_vec;
         irq_level  = hi_level;
      end
   end

   assign irq_kind    = kind;
   assign irq_pending = (|pend) || hi_valid;

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
      $onehot0({grant, fixed_grant}))
      else $error("more than one interrupt selected"); // R7
   AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
      msg_valid && (mode == DM_RSV3 || mode == DM_RSV6) && !ack
      |=> $stable(pend) && $stable(hi_valid) && $stable(hi_vec))
      else $error("reserved mode changed state"); // R6
   AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
      msg_valid && !hit && !ack
      |=> $stable(pend) && $stable(hi_valid) && $stable(hi_vec))
      else $error("misaddressed message changed state"); // R8
   AST_IDLE_ACK: assert property (@(posedge clk) disable iff (rst)
      !irq_pending && ack && !msg_valid |=> !irq_pending)
      else $error("ack with nothing pending created state"); // R9
endmodule

// File: tb/irq_accept_arb_tb.sv
module irq_accept_arb_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] local_id = 3'd5;
   logic       msg_valid = 1'b0;
   logic [7:0] msg_vector = '0;
   logic [2:0] msg_mode = '0;
   logic       msg_level = 1'b0;
   logic       msg_dest_logical = 1'b0;
   logic [7:0] msg_dest = '0;
   logic       ack = 1'b0;
   logic       irq_pending, irq_level, unmask_pending;
   logic [2:0] irq_kind;
   logic [7:0] irq_vector;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_accept_arb u_dut (
      .clk(clk), .rst(rst), .local_id(local_id),
      .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_mode(msg_mode),
      .msg_level(msg_level), .msg_dest_logical(msg_dest_logical), .msg_dest(msg_dest),
      .ack(ack), .irq_pending(irq_pending), .irq_kind(irq_kind),
      .irq_vector(irq_vector), .irq_level(irq_level), .unmask_pending(unmask_pending));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expect kind, vector, pending, unmask
   task automatic see(input string req, input int k, input int v, input int p, input int u);
      chk({req, " kind"}, irq_kind, k);
      if (k != 0) chk({req, " vector"}, irq_vector, v);
      chk({req, " pending"}, irq_pending, p);
      chk({req, " unmask"}, unmask_pending, u);
   endtask

   task automatic send(input logic [7:0] v, input logic [2:0] m, input logic lvl,
                       input logic lg, input logic [7:0] d);
      msg_valid = 1'b1; msg_vector = v; msg_mode = m; msg_level = lvl;
      msg_dest_logical = lg; msg_dest = d;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   task automatic send_here(input logic [7:0] v, input logic [2:0] m, input logic lvl);
      send(v, m, lvl, 1'b0, 8'd5);
   endtask

   task automatic do_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic t_reset();
      see("R11 reset", 0, 0, 0, 0);
      do_ack();
      see("R9 idle ack", 0, 0, 0, 0);
   endtask

   task automatic t_fixed_order();
      send_here(8'h20, 3'b000, 1'b0);
      send_here(8'h80, 3'b001, 1'b1);
      send_here(8'h40, 3'b000, 1'b0);
      see("R2 highest", 5, 8'h80, 1, 0);
      chk("R1 level of 0x80", irq_level, 1);
      do_ack();
      see("R9 next highest", 5, 8'h40, 1, 0);
      chk("R1 edge of 0x40", irq_level, 0);
      do_ack();
      see("R9 last", 5, 8'h20, 1, 0);
      do_ack();
      see("R10 drained", 0, 0, 0, 0);
   endtask

   task automatic t_trigger_keep();
      send_here(8'h33, 3'b000, 1'b0);
      send_here(8'h33, 3'b000, 1'b1);
      see("R1 repeat", 5, 8'h33, 1, 0);
      chk("R1 trigger kept", irq_level, 0);
      do_ack();
      send_here(8'h33, 3'b000, 1'b1);
      chk("R1 trigger after clear", irq_level, 1);
      do_ack();
      see("R1 drained", 0, 0, 0, 0);
   endtask

   task automatic t_priority();
      send_here(8'h90, 3'b000, 1'b0);
      send_here(8'h11, 3'b111, 1'b0);
      see("R5 ext no unmask", 4, 8'h11, 1, 0);
      send_here(8'h22, 3'b101, 1'b0);
      send_here(8'h33, 3'b100, 1'b0);
      send_here(8'h44, 3'b010, 1'b0);
      see("R7 smi first", 1, 8'h44, 1, 1);
      do_ack();
      see("R7 nmi second", 2, 8'h33, 1, 1);
      do_ack();
      see("R7 init third", 3, 8'h22, 1, 1);
      do_ack();
      see("R7 ext fourth", 4, 8'h11, 1, 0);
      do_ack();
      see("R3 fixed untouched", 5, 8'h90, 1, 0);
      do_ack();
      see("R3 drained", 0, 0, 0, 0);
   endtask

   task automatic t_first_kept();
      send_here(8'h05, 3'b100, 1'b0);
      send_here(8'h06, 3'b100, 1'b0);
      see("R4 first vector kept", 2, 8'h05, 1, 1);
      do_ack();
      see("R4 single slot", 0, 0, 0, 0);
   endtask

   task automatic t_reserved();
      send_here(8'h50, 3'b011, 1'b0);
      send_here(8'h51, 3'b110, 1'b1);
      see("R6 reserved dropped", 0, 0, 0, 0);
   endtask

   task automatic t_dest();
      send(8'h61, 3'b000, 1'b0, 1'b0, 8'd3);
      see("R8 physical mismatch", 0, 0, 0, 0);
      send(8'h62, 3'b000, 1'b0, 1'b1, 8'b1101_1111);
      see("R8 logical bit clear", 0, 0, 0, 0);
      send(8'h63, 3'b000, 1'b0, 1'b1, 8'b0010_0000);
      see("R8 logical bit set", 5, 8'h63, 1, 0);
      do_ack();
      send(8'h64, 3'b010, 1'b0, 1'b0, 8'd5);
      see("R8 physical match", 1, 8'h64, 1, 1);
      do_ack();
      see("R8 drained", 0, 0, 0, 0);
   endtask

   task automatic t_edges();
      send_here(8'h00, 3'b000, 1'b1);
      see("R2 vector zero", 5, 0, 1, 0);
      send_here(8'hFF, 3'b000, 1'b0);
      see("R2 vector 255", 5, 255, 1, 0);
      do_ack();
      see("R2 back to zero", 5, 0, 1, 0);
      chk("R1 level zero", irq_level, 1);
      do_ack();
      see("R10 empty", 0, 0, 0, 0);
   endtask

   task automatic t_reset_mid();
      send_here(8'h70, 3'b000, 1'b0);
      send_here(8'h71, 3'b101, 1'b0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      see("R11 reset clears", 0, 0, 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_fixed_order();
      t_trigger_keep();
      t_priority();
      t_first_kept();
      t_reserved();
      t_dest();
      t_edges();
      t_reset_mid();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule